// File: doc/BRIEF.md
# I2C Command Word Packer

This block turns a list of I2C messages into 32-bit command words for a byte-oriented I2C master. The messages arrive as one byte stream. Each message starts with a header beat that carries a 7-bit slave address and a read flag. The data beats of that message follow it. A flag on the final beat marks the end of the list.

The packer places three bytes in each word. Every byte gets a 2-bit attribute code:

- The address byte of a message is tagged START.
- A data byte is tagged CONT.
- The very last byte of the list is tagged STOP if it is a data byte.

Words are held in an internal buffer of `BUF_BYTES` bytes. They are released in order on a valid/ready output stream only after the whole list has been taken in. The block reports the word count of every list. If the packed list would not fit the buffer, it raises an out-of-memory flag instead and emits nothing.

Input back-pressure works as follows. `in_ready` falls in the cycle after the final beat is accepted. It stays low until the last word of that list has been accepted at the output. If the list overflowed, no word is emitted and `in_ready` does not fall.

Output back-pressure works as follows. While `out_valid` is high and `out_ready` is low, `out_word` holds its value. A word is consumed on a cycle where both are high.

Top module: `i2c_cmd_packer`

## Requirements
- R1: The address byte of a message is `{addr[6:0], rd}`, with the read flag in bit 0. Its attribute is START, encoded 2'b11.
- R2: Each data byte follows its address byte in stream order. Its attribute is CONT, encoded 2'b10, unless R4 applies.
- R3: Byte slot k (k = 0, 1, 2) of a word holds its byte at bits [31-8k:24-8k] and its attribute at bits [7-2k:6-2k]. Bits [1:0] are always zero. Slots past the final byte, and their attribute bits, are zero. Messages share words, so an address byte may sit in any slot.
- R4: If the final byte of a list is a data byte, its attribute is STOP, encoded 2'b01. If the final byte is an address byte, it keeps START.
- R5: One cycle after the final beat is accepted, `done` pulses for one cycle. At the same time `word_count` shows ceil(total_bytes/3), where total_bytes counts one address byte per message plus all data bytes.
- R6: If 4 × word_count exceeds `BUF_BYTES`, `oom` is high with `done`. No word of that list is emitted, and the next list is accepted at once.
- R7: Words leave in packing order. While `out_valid` is high and `out_ready` is low, `out_word` stays stable.
- R8: `in_ready` is low from the cycle after a fitting list's final beat until its last word is accepted.
- R9: After reset, `in_ready` is 1 and both `out_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Packer can take a beat |
| in_hdr | input | 1 | Beat is a message header (address) |
| in_rd | input | 1 | Read flag, used on header beats |
| in_last | input | 1 | Final beat of the message list |
| in_data | input | 8 | Address in [6:0] on a header, data byte otherwise |
| out_valid | output | 1 | Command word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Packed command word |
| done | output | 1 | One-cycle pulse when a list has been packed |
| word_count | output | CNT_W | Words produced by the last list |
| oom | output | 1 | Last list did not fit the buffer |

## Verification
The bench aims at the following corner cases:

- **Final byte in a middle slot.** A design that pads wrongly or fails to flush the partial word would leave stale bytes in the trailing slots, or drop the word altogether.
- **Final byte is a header.** A fix-up applied blindly would turn the START tag into STOP.
- **Lists of exactly the buffer size and one byte more.** An off-by-one in the overflow test would either emit a 17th word into a 16-word buffer or reject a list that fits.
- **Random output stalls.** These expose a word that changes while stalled, and a list that follows an overflow shows whether the block recovers without emitting stale words.

// File: rtl/i2cpk_pkg.sv
package i2cpk_pkg;
  typedef enum logic [1:0] {
    TAG_NOP   = 2'b00,
    TAG_STOP  = 2'b01,
    TAG_CONT  = 2'b10,
    TAG_START = 2'b11
  } tag_e;

  localparam int SLOTS = 3;

  // insert byte b with attribute t into slot s of word w
  function automatic logic [31:0] put_slot(logic [31:0] w, logic [1:0] s,
                                           logic [7:0] b, tag_e t);
    logic [31:0] r;
    r = w;
    r[24 - 8*s +: 8] = b;
    r[6 - 2*s +: 2]  = t;
    return r;
  endfunction
endpackage

// File: rtl/i2cpk_slot_fill.sv
module i2cpk_slot_fill
  import i2cpk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             hdr,
  input  logic             rd,
  input  logic             last,
  input  logic [7:0]       data,
  output logic             cm_valid,
  output logic [31:0]      cm_word,
  output logic [CNT_W-1:0] cm_idx,
  output logic             list_end,
  output logic [CNT_W-1:0] total_words,
  output logic             over
);
  logic [31:0]      acc;
  logic [1:0]       slot;
  logic [CNT_W-1:0] widx;
  logic [7:0]       beat_byte;
  tag_e             beat_tag;

  always_comb begin
    beat_byte = hdr ? {data[6:0], rd} : data;
    if (hdr)       beat_tag = TAG_START;
    else if (last) beat_tag = TAG_STOP;   // final data byte closes the list
    else           beat_tag = TAG_CONT;
  end

  assign cm_word     = put_slot(acc, slot, beat_byte, beat_tag);
  assign cm_valid    = take && (slot == 2'(SLOTS - 1) || last);
  assign cm_idx      = widx;
  assign list_end    = take && last;
  assign total_words = widx + 1'b1;
  assign over        = (widx >= CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      slot <= '0;
      widx <= '0;
    end else if (take) begin
      if (cm_valid) begin
        acc  <= '0;
        slot <= '0;
        widx <= last ? '0 : widx + 1'b1;
      end else begin
        acc  <= cm_word;
        slot <= slot + 1'b1;
      end
    end
  end

  // R3: committed words keep the pad bits clear and always fill slot 0
  a_r3_pad_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> (cm_word[1:0] == 2'b00 && cm_word[7:6] != 2'b00));
  // R5: the slot position restarts for the next list
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    list_end |=> (slot == 2'b00 && widx == '0));
endmodule

// File: rtl/i2cpk_word_store.sv
module i2cpk_word_store #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_req,
  input  logic [CNT_W-1:0] wr_idx,
  input  logic [31:0]      wr_word,
  input  logic [AW-1:0]    rd_idx,
  output logic [31:0]      rd_word
);
  logic [31:0] mem [DEPTH];
  logic        in_range;

  assign in_range = (wr_idx < CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_req && in_range) mem[wr_idx[AW-1:0]] <= wr_word;
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/i2cpk_drain.sv
module i2cpk_drain #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             list_end,
  input  logic             over,
  input  logic [CNT_W-1:0] total_words,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [AW-1:0]    rd_idx,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] word_count,
  output logic             oom
);
  logic [AW-1:0] last_idx;

  assign out_valid = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      oom        <= 1'b0;
      word_count <= '0;
      rd_idx     <= '0;
      last_idx   <= '0;
    end else begin
      done <= list_end;
      if (list_end) begin
        word_count <= total_words;
        oom        <= over;
        busy       <= !over;
        rd_idx     <= '0;
        last_idx   <= AW'(total_words - 1'b1);
      end else if (busy && out_ready) begin
        rd_idx <= rd_idx + 1'b1;
        if (rd_idx == last_idx) busy <= 1'b0;
      end
    end
  end

  // R7: a stalled word keeps its position
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(rd_idx)));
  // R6: an overflowed list never drives words
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done && oom) |-> !out_valid);
  // R8: no list may end while words are draining
  a_r8_no_end: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !list_end);
  // R5: a finished list always reports at least one word
  a_r5_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (word_count != '0));
endmodule

// File: rtl/i2c_cmd_packer.sv
module i2c_cmd_packer #(
  parameter int BUF_BYTES = 64,
  parameter int CNT_W     = 16,
  localparam int DEPTH = (BUF_BYTES / 4 > 0) ? BUF_BYTES / 4 : 1,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_hdr,
  input  logic             in_rd,
  input  logic             in_last,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_word,
  output logic             done,
  output logic [CNT_W-1:0] word_count,
  output logic             oom
);
  logic             take, cm_valid, list_end, over, busy;
  logic [31:0]      cm_word;
  logic [CNT_W-1:0] cm_idx, total_words;
  logic [AW-1:0]    rd_idx;

  assign in_ready = !busy;
  assign take     = in_valid && in_ready;

  i2cpk_slot_fill #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .take(take), .hdr(in_hdr), .rd(in_rd),
    .last(in_last), .data(in_data), .cm_valid(cm_valid), .cm_word(cm_word),
    .cm_idx(cm_idx), .list_end(list_end), .total_words(total_words),
    .over(over)
  );

  i2cpk_word_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk(clk), .wr_req(cm_valid), .wr_idx(cm_idx), .wr_word(cm_word),
    .rd_idx(rd_idx), .rd_word(out_word)
  );

  i2cpk_drain #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_drain (
    .clk(clk), .rst_n(rst_n), .list_end(list_end), .over(over),
    .total_words(total_words), .out_ready(out_ready), .out_valid(out_valid),
    .rd_idx(rd_idx), .busy(busy), .done(done), .word_count(word_count),
    .oom(oom)
  );

  // R7: word content stays put under back-pressure
  a_r7_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_word));
  // R3: emitted words never use the pad bits
  a_r3_out_pad: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word[1:0] == 2'b00));
endmodule

// File: tb/i2c_cmd_packer_bench.sv
`timescale 1ns/1ps
module i2c_cmd_packer_bench;
  localparam int BUF_BYTES = 64;
  localparam int CNT_W     = 16;
  localparam int DEPTH     = BUF_BYTES / 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_hdr = 1'b0, in_rd = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, done, oom;
  logic [31:0] out_word;
  logic [CNT_W-1:0] word_count;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  bit   b_hdr[$], b_rd[$];
  logic [7:0] b_dat[$];
  logic [15:0] lfsr = 16'hACE1;
  bit   stall_mode = 0;

  always #2 clk = ~clk;

  i2c_cmd_packer #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_i2c_cmd_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_rd(in_rd), .in_last(in_last), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .done(done), .word_count(word_count), .oom(oom)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic add_msg(logic [6:0] addr, bit rd, int len, int seed);
    b_hdr.push_back(1); b_rd.push_back(rd); b_dat.push_back({1'b0, addr});
    for (int i = 0; i < len; i++) begin
      b_hdr.push_back(0); b_rd.push_back(0); b_dat.push_back(8'(seed * 7 + i * 13));
    end
  endtask

  // builds the expected words from the requirements, then drives the beats
  task automatic run_list(string tag);
    int n, words;
    bit exp_oom;
    logic [31:0] w [$];
    n = b_hdr.size();
    words = (n + 2) / 3;
    exp_oom = (4 * words > BUF_BYTES);
    for (int i = 0; i < words; i++) w.push_back(32'h0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] by;
      logic [1:0] tg;
      int k;
      k = i % 3;
      by = b_hdr[i] ? {b_dat[i][6:0], b_rd[i]} : b_dat[i];       // R1
      tg = b_hdr[i] ? 2'b11 : ((i == n - 1) ? 2'b01 : 2'b10);   // R1 R2 R4
      w[i / 3][24 - 8 * k +: 8] = by;                            // R3
      w[i / 3][6 - 2 * k +: 2]  = tg;
    end
    if (!exp_oom) foreach (w[i]) exp_q.push_back(w[i]);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1; in_hdr = b_hdr[i]; in_rd = b_rd[i];
      in_data = b_dat[i]; in_last = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    check(done === 1'b1, {"R5 done ", tag}, 32'(done), 1);
    check(word_count === CNT_W'(words), {"R5 count ", tag}, 32'(word_count), words);
    check(oom === exp_oom, {"R6 oom ", tag}, 32'(oom), 32'(exp_oom));
    if (exp_oom) check(in_ready === 1'b1 && out_valid === 1'b0, {"R6 no emit ", tag},
                       {30'b0, in_ready, out_valid}, 32'h2);
    else check(in_ready === 1'b0, {"R8 in_ready low ", tag}, 32'(in_ready), 0);
    b_hdr.delete(); b_rd.delete(); b_dat.delete();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0, {"R8 release ", tag},
          {30'b0, in_ready, out_valid}, 32'h2);
  endtask

  // monitor / scoreboard
  initial begin
    bit held;
    logic [31:0] held_w;
    held = 0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = stall_mode ? lfsr[0] : 1'b1;
      #0.5;
      if (rst_n) begin
        if (held) check(out_valid === 1'b1 && out_word === held_w,
                        "R7 stall stable", out_word, held_w);
        held = 0;
        if (out_valid === 1'b1) begin
          if (out_ready) begin
            if (exp_q.size() == 0) check(0, "R7 unexpected word", out_word, 0);
            else begin
              logic [31:0] e;
              e = exp_q.pop_front();
              check(out_word === e, "R1 R2 R3 R4 R7 word", out_word, e);
            end
          end else begin
            held = 1; held_w = out_word;
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0 && done === 1'b0, "R9 reset",
          {29'b0, in_ready, out_valid, done}, 32'h4);
    rst_n = 1;
    @(negedge clk);
    // R2 R4: one write, final data byte becomes STOP
    add_msg(7'h50, 0, 2, 1); run_list("single write");
    // R4: final byte is a header, stays START; R3 unused slots zero
    add_msg(7'h3A, 1, 0, 2); run_list("bare read");
    // R3: address in a later slot, messages share words
    add_msg(7'h21, 0, 1, 3); add_msg(7'h21, 1, 3, 4); run_list("write then read");
    stall_mode = 1;
    // R7: several words under random stalls
    add_msg(7'h11, 0, 4, 5); add_msg(7'h12, 1, 2, 6); add_msg(7'h13, 0, 0, 7);
    run_list("three msgs stalled");
    // R6 boundary: exactly the buffer (48 bytes, 16 words)
    add_msg(7'h44, 0, 47, 8); run_list("full buffer");
    // R6: one byte over, 17 words
    add_msg(7'h45, 0, 48, 9); run_list("overflow");
    // R6: recovery after overflow
    stall_mode = 0;
    add_msg(7'h7F, 1, 4, 10); run_list("after overflow");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule